// File: doc/BRIEF.md
# Inter-Core Doorbell Dispatcher

This block carries doorbell interrupts between the cores of a cluster of `NCORES` processors. Any core may post a send message word. The block decodes the word's kind field and works out which cores it is aimed at, either by broadcast or by matching a target tag against each core's processor identifier. Each aimed-at core then latches a pending doorbell bit of the selected flavour, normal or critical, and sees a one-cycle interrupt request.

A core acknowledges its own doorbell with a clear operation. The clear carries the issuing core's index and a kind code, and drops that one pending bit on that one core. Kinds reserved for guest doorbells, and any undefined kinds, are decoded as no-ops for both send and clear.

Processor identifiers are fixed by parameters and loaded into each core slot when reset is released. The identifier of core `i` is `ID_BASE + i*ID_STEP`.

Top module: `doorbell_dispatch`

## Requirements
- R1: Kind field `snd_msg_i[31:29]` (and `clr_kind_i`) decodes 0 as normal doorbell and 1 as critical doorbell. Codes 2, 3 and 4 (guest normal, guest critical, guest machine-check) and codes 5 to 7 are ignored. An ignored send sets no pending bit and raises no `irq_o`.
- R2: A send aims at core `i` when broadcast bit `snd_msg_i[28]` is 1, or when tag field `snd_msg_i[27:0]` equals `ID_BASE + i*ID_STEP`. A tag that matches no core reaches no core.
- R3: A valid send sets the decoded pending bit (`pend_norm_o[i]` or `pend_crit_o[i]`) of every aimed-at core, visible one cycle after the send cycle. It leaves the other flavour untouched.
- R4: `irq_o[i]` is high for exactly the one cycle after each valid, decoded send that aims at core `i`. Back-to-back sends give back-to-back pulses.
- R5: A clear with kind 0 or 1 drops that flavour's pending bit of core `clr_core_i` only, one cycle later. The other cores and the other flavour keep their state.
- R6: A clear with an ignored kind (2 to 7) changes no pending bit.
- R7: When a send sets and a clear drops the same bit of the same core in one cycle, the bit ends up set.
- R8: While `rst_ni` is low, all pending bits and `irq_o` are 0.
- R9: With no send and no clear, every pending bit holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| snd_vld_i | input | 1 | Send operation this cycle |
| snd_msg_i | input | MSG_W (32) | Send word: kind [31:29], broadcast [28], tag [27:0] |
| clr_vld_i | input | 1 | Clear operation this cycle |
| clr_core_i | input | $clog2(NCORES) | Index of the core issuing the clear |
| clr_kind_i | input | 3 | Kind code of the clear |
| pend_norm_o | output | NCORES | Normal doorbell pending, one bit per core |
| pend_crit_o | output | NCORES | Critical doorbell pending, one bit per core |
| irq_o | output | NCORES | One-cycle interrupt request per core |

## Verification
A wrong internal state in this block shows up at the ports one cycle after the operation that caused it. Each bit in `pend_norm_o` or `pend_crit_o` is a register brought straight out. A mis-decoded kind or a wrong tag compare is therefore seen on the very next cycle, as a bit set on the wrong core or in the wrong flavour, or as a missing or extra `irq_o` pulse. A bad hold or clear path shows up in the cycles after a clear or an idle cycle. The bench compares all three output vectors against its own model on every cycle, so it catches such a bit on the cycle it goes wrong and not at the end of the run.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;
  localparam int KIND_W = 3;

  typedef enum logic [1:0] {
    DB_NONE = 2'd0,
    DB_NORM = 2'd1,
    DB_CRIT = 2'd2
  } db_kind_e;

  localparam logic [KIND_W-1:0] K_NORM = 3'd0;
  localparam logic [KIND_W-1:0] K_CRIT = 3'd1;
endpackage

// File: rtl/doorbell_kind_dec.sv
module doorbell_kind_dec
  import doorbell_pkg::*;
(
  input  logic [KIND_W-1:0] code_i,
  output db_kind_e          kind_o
);
  // guest and undefined codes fall through to DB_NONE
  always_comb begin
    unique case (code_i)
      K_NORM:  kind_o = DB_NORM;
      K_CRIT:  kind_o = DB_CRIT;
      default: kind_o = DB_NONE;
    endcase
  end
endmodule

// File: rtl/doorbell_slot.sv
module doorbell_slot
  import doorbell_pkg::*;
#(
  parameter int TAG_W   = 28,
  parameter int ID_BASE = 32,
  parameter int ID_STEP = 3,
  parameter int IDX     = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             snd_vld_i,
  input  db_kind_e         snd_kind_i,
  input  logic             snd_bcast_i,
  input  logic [TAG_W-1:0] snd_tag_i,
  input  logic             clr_sel_i,
  input  db_kind_e         clr_kind_i,
  output logic             pend_norm_o,
  output logic             pend_crit_o,
  output logic             irq_o
);
  localparam logic [TAG_W-1:0] MY_ID = TAG_W'(ID_BASE + IDX * ID_STEP);

  logic [TAG_W-1:0] id_q;
  logic hit, set_n, set_c, clr_n, clr_c;
  logic pn_q, pc_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) id_q <= MY_ID;
    else         id_q <= id_q;
  end

  assign hit   = snd_vld_i && (snd_bcast_i || (snd_tag_i == id_q));
  assign set_n = hit && (snd_kind_i == DB_NORM);
  assign set_c = hit && (snd_kind_i == DB_CRIT);
  assign clr_n = clr_sel_i && (clr_kind_i == DB_NORM);
  assign clr_c = clr_sel_i && (clr_kind_i == DB_CRIT);

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pn_q  <= 1'b0;
      pc_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      pn_q  <= set_n | (pn_q & ~clr_n);
      pc_q  <= set_c | (pc_q & ~clr_c);
      irq_q <= set_n | set_c;
    end
  end

  assign pend_norm_o = pn_q;
  assign pend_crit_o = pc_q;
  assign irq_o       = irq_q;

  p_set_norm_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && snd_kind_i == DB_NORM) |=> pend_norm_o);
  p_set_crit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && snd_kind_i == DB_CRIT) |=> pend_crit_o);
  p_clr_norm_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_n && !set_n) |=> !pend_norm_o);
  p_set_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_c && clr_c) |=> pend_crit_o);
  p_irq_src_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(snd_vld_i));
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!snd_vld_i && !clr_sel_i) |=> ($stable(pend_norm_o) && $stable(pend_crit_o) && !irq_o));
endmodule

// File: rtl/doorbell_dispatch.sv
module doorbell_dispatch
  import doorbell_pkg::*;
#(
  parameter int NCORES  = 4,
  parameter int MSG_W   = 32,
  parameter int ID_BASE = 32,
  parameter int ID_STEP = 3,
  localparam int CW     = $clog2(NCORES),
  localparam int TAG_W  = MSG_W - KIND_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              snd_vld_i,
  input  logic [MSG_W-1:0]  snd_msg_i,
  input  logic              clr_vld_i,
  input  logic [CW-1:0]     clr_core_i,
  input  logic [KIND_W-1:0] clr_kind_i,
  output logic [NCORES-1:0] pend_norm_o,
  output logic [NCORES-1:0] pend_crit_o,
  output logic [NCORES-1:0] irq_o
);
  db_kind_e         snd_kind, clr_kind;
  logic             snd_bcast;
  logic [TAG_W-1:0] snd_tag;

  assign snd_bcast = snd_msg_i[TAG_W];
  assign snd_tag   = snd_msg_i[TAG_W-1:0];

  doorbell_kind_dec u_snd_dec (.code_i(snd_msg_i[MSG_W-1 -: KIND_W]), .kind_o(snd_kind));
  doorbell_kind_dec u_clr_dec (.code_i(clr_kind_i), .kind_o(clr_kind));

  for (genvar i = 0; i < NCORES; i++) begin : g_slot
    logic sel;
    assign sel = clr_vld_i && (clr_core_i == CW'(i));
    doorbell_slot #(
      .TAG_W(TAG_W), .ID_BASE(ID_BASE), .ID_STEP(ID_STEP), .IDX(i)
    ) u_slot (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .snd_vld_i   (snd_vld_i),
      .snd_kind_i  (snd_kind),
      .snd_bcast_i (snd_bcast),
      .snd_tag_i   (snd_tag),
      .clr_sel_i   (sel),
      .clr_kind_i  (clr_kind),
      .pend_norm_o (pend_norm_o[i]),
      .pend_crit_o (pend_crit_o[i]),
      .irq_o       (irq_o[i])
    );
  end

  p_ignore_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snd_vld_i && snd_kind == DB_NONE) |=> (irq_o == '0));
  p_clr_ign_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!snd_vld_i && clr_vld_i && clr_kind == DB_NONE) |=>
      ($stable(pend_norm_o) && $stable(pend_crit_o)));
  p_irq_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snd_vld_i && !snd_bcast) |=> $onehot0(irq_o));
endmodule

// File: tb/doorbell_dispatch_tb.sv
module doorbell_dispatch_tb;
  localparam int N = 4, MW = 32, IB = 32, IS = 3, CW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic snd_vld = 1'b0, clr_vld = 1'b0;
  logic [MW-1:0] snd_msg = '0;
  logic [CW-1:0] clr_core = '0;
  logic [2:0]    clr_kind = '0;
  logic [N-1:0]  pn, pc, irq;

  always #4 clk = ~clk;

  doorbell_dispatch u_dut (
    .clk_i(clk), .rst_ni(rst_n), .snd_vld_i(snd_vld), .snd_msg_i(snd_msg),
    .clr_vld_i(clr_vld), .clr_core_i(clr_core), .clr_kind_i(clr_kind),
    .pend_norm_o(pn), .pend_crit_o(pc), .irq_o(irq));

  typedef struct { logic [N-1:0] n, c, q; string req; } exp_t;
  exp_t sb[$];
  int total = 0, bad = 0;
  logic [N-1:0] mn = '0, mc = '0;

  function automatic logic [MW-1:0] mk(input int k, input bit bc, input int tag);
    return {3'(k), bc, 28'(tag)};
  endfunction

  task automatic op(input bit sv, input logic [MW-1:0] sm, input bit cv,
                    input int cc, input int ck, input string req);
    exp_t e;
    logic [N-1:0] hit = '0;
    @(negedge clk);
    snd_vld = sv; snd_msg = sm; clr_vld = cv; clr_core = CW'(cc); clr_kind = 3'(ck);
    for (int i = 0; i < N; i++)
      hit[i] = sv && (sm[28] || sm[27:0] == 28'(IB + i*IS));
    if (cv && ck == 0) mn[cc] = 1'b0;
    if (cv && ck == 1) mc[cc] = 1'b0;
    e.q = '0;
    if (sm[31:29] == 3'd0) begin mn = mn | hit; e.q = hit; end
    if (sm[31:29] == 3'd1) begin mc = mc | hit; e.q = hit; end
    e.n = mn; e.c = mc; e.req = req;
    sb.push_back(e);
  endtask

  task automatic idle(input string req);
    op(1'b0, '0, 1'b0, 0, 0, req);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk); #2;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        total++;
        if (pn !== e.n || pc !== e.c || irq !== e.q) begin
          bad++;
          $display("FAIL %s: got n=%b c=%b irq=%b exp n=%b c=%b irq=%b",
                   e.req, pn, pc, irq, e.n, e.c, e.q);
        end
      end
    end
  end

  initial begin : watchdog
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog: got hung exp done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #20;
    total++;
    if (pn !== '0 || pc !== '0 || irq !== '0) begin
      bad++;
      $display("FAIL R8: got n=%b c=%b irq=%b exp 0", pn, pc, irq);
    end
    @(negedge clk); rst_n = 1'b1;
    idle("R8");
    op(1, mk(0, 0, IB + IS), 0, 0, 0, "R3 tag core1 normal");
    op(1, mk(1, 1, 0), 0, 0, 0, "R2 broadcast critical");
    op(1, mk(2, 1, 0), 0, 0, 0, "R1 guest normal");
    op(1, mk(3, 1, 0), 0, 0, 0, "R1 guest critical");
    op(1, mk(4, 1, 0), 0, 0, 0, "R1 guest mcheck");
    op(1, mk(7, 1, 0), 0, 0, 0, "R1 undefined kind");
    op(1, mk(0, 0, IB + 1), 0, 0, 0, "R2 no tag match");
    op(1, mk(0, 0, IB + 3*IS), 0, 0, 0, "R4 core3 pulse a");
    op(1, mk(0, 0, IB), 0, 0, 0, "R4 core0 pulse b");
    idle("R9 hold");
    idle("R9 hold");
    op(0, '0, 1, 1, 0, "R5 clear core1 normal");
    op(0, '0, 1, 3, 1, "R5 clear core3 critical");
    op(0, '0, 1, 0, 4, "R6 ignored clear kind");
    op(0, '0, 1, 2, 6, "R6 undefined clear kind");
    op(1, mk(0, 0, IB + 2*IS), 1, 2, 0, "R7 set wins normal");
    op(1, mk(1, 0, IB + 2*IS), 1, 2, 1, "R7 set wins critical");
    op(1, mk(1, 0, IB), 1, 1, 1, "R5 clear other core during send");
    op(1, mk(0, 1, 0), 0, 0, 0, "R2 broadcast normal");
    idle("R4 pulse ends");
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule